// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block combines an 8-bit event counter and a watchdog that share one 8-bit prescaler. A 6-bit mode register chooses the counter's clock source (the instruction-cycle tick or a synchronised edge on an external pin), the active pin edge, which of the two timers owns the prescaler, and the division exponent. The timer that does not own the prescaler is stepped directly by its own source.

The watchdog counts steps of its own free-running tick and, when enabled, raises a one-cycle reset pulse after a parameterised number of steps. The block also keeps the timeout and power-down status flags and reacts to clear-watchdog, sleep and master-clear requests from the surrounding core, setting those flags according to whether the core was asleep.

Top module: `tmr_wdog_unit`

## Requirements
- R1: After `rst_n` is released, `mode_q` is 6'h3F, `count_q` is 8'h00, `flag_to` and `flag_pd` are both 1, `asleep` is 0, and `cnt_wrap` and `wdt_rst` are 0.
- R2: Mode bits are `[5]` source (1 = pin, 0 = cycle tick), `[4]` edge (1 = falling, 0 = rising), `[3]` prescaler owner (1 = watchdog, 0 = counter), `[2:0]` exponent `ps`; a write appears on `mode_q` the next cycle and zeroes the prescaler.
- R3: With the prescaler on the counter, `count_q` advances once per 2^(ps+1) source ticks (ps=0 gives 1:2, ps=7 gives 1:256).
- R4: With the prescaler on the watchdog, `count_q` advances on every source tick and the watchdog steps once per 2^ps watchdog ticks.
- R5: In pin mode the pin goes through a two-flop synchroniser and only the selected edge advances the counter; the other edge and `cyc_tick` have no effect.
- R6: `count_q` wraps from 8'hFF to 8'h00 and `cnt_wrap` is high for exactly the cycle in which `count_q` shows 8'h00; a load through `cnt_we` wins over a same-cycle step and zeroes the prescaler when the counter owns it.
- R7: With `wdt_en` high, the watchdog step that reaches `WDT_LIMIT` steps since the last clear gives a one-cycle `wdt_rst`, sets `mode_q` to 6'h3F and leaves sleep; with `wdt_en` low `wdt_rst` never rises.
- R8: `clrwdt` restarts the watchdog count, sets `flag_to` and `flag_pd` to 1, and zeroes the prescaler when the watchdog owns it.
- R9: `sleep_cmd` sets `asleep`, sets both flags to 1 and restarts the watchdog; while asleep the cycle-tick source does not advance the counter.
- R10: A watchdog expiry outside sleep gives `flag_to`=0, `flag_pd`=1; during sleep it gives 0 and 0.
- R11: `mclr_req` sets `mode_q` to 6'h3F, leaves sleep, restarts watchdog and prescaler and keeps `count_q`; if asleep the flags become `flag_to`=1, `flag_pd`=0, otherwise they keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cyc_tick | input | 1 | Instruction-cycle tick, one clock wide |
| wdt_tick | input | 1 | Free-running watchdog tick, one clock wide |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_en | input | 1 | Watchdog enable option |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 6 | Mode register write data |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load data |
| clrwdt | input | 1 | Clear-watchdog request |
| sleep_cmd | input | 1 | Enter-sleep request |
| mclr_req | input | 1 | Master-clear reset request |
| mode_q | output | 6 | Current mode register |
| count_q | output | CNT_W | Current counter value |
| cnt_wrap | output | 1 | Counter wrapped to zero this cycle |
| wdt_rst | output | 1 | Watchdog reset pulse |
| asleep | output | 1 | Sleep state |
| flag_to | output | 1 | Timeout status flag |
| flag_pd | output | 1 | Power-down status flag |

## Verification
The properties assume that `cyc_tick`, `wdt_tick` and the request strobes are synchronous to `clk` and that at most one of `clrwdt`, `sleep_cmd` and `mclr_req` is high in any cycle; the bench drives every strobe for one clock from the falling edge and never overlaps two requests. The pin is treated as asynchronous, so the bench only samples the count several clocks after each pin change, giving the synchroniser time to settle. The watchdog limit is shortened through its parameter so expiries fit in a short run.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int PS_W  = 3;
  localparam int EXP_W = PS_W + 1;
  localparam int PRE_W = 1 << PS_W;
  localparam int MODE_W = PS_W + 3;

  typedef struct packed {
    logic            src_pin;
    logic            fall_edge;
    logic            pre_wd;
    logic [PS_W-1:0] ps;
  } mode_t;

  // Division exponent: the watchdog owner divides by 2^ps, the counter by 2^(ps+1).
  function automatic logic [EXP_W-1:0] div_exp(input logic [PS_W-1:0] ps, input logic to_wd);
    return to_wd ? EXP_W'(ps) : EXP_W'(ps) + EXP_W'(1);
  endfunction

  // Low-bit mask whose all-ones state marks the last input of a division period.
  function automatic logic [PRE_W:0] span_mask(input logic [EXP_W-1:0] e);
    return ((PRE_W+1)'(1) << e) - (PRE_W+1)'(1);
  endfunction
endpackage

// File: rtl/tw_pin_edge.sv
module tw_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_pulse
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign edge_pulse = fall_sel ? (s3 & ~s2) : (s2 & ~s3);
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler
  import tw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             carry
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   mask;

  assign mask  = span_mask(exp_sel);
  assign carry = inc && (({1'b0, pre_q} & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (inc) pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/tw_wdog.sv
module tw_wdog #(
  parameter int LIMIT = 20000,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         step,
  output logic         expire,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  assign expire = en && step && !clr && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr || !en)     cnt_q <= '0;
    else if (expire)         cnt_q <= '0;
    else if (step)           cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/tmr_wdog_unit.sv
module tmr_wdog_unit
  import tw_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int WDT_LIMIT = 20000,
  parameter int WDT_W     = $clog2(WDT_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_tick,
  input  logic              wdt_tick,
  input  logic              ext_pin,
  input  logic              wdt_en,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              clrwdt,
  input  logic              sleep_cmd,
  input  logic              mclr_req,
  output logic [MODE_W-1:0] mode_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              cnt_wrap,
  output logic              wdt_rst,
  output logic              asleep,
  output logic              flag_to,
  output logic              flag_pd
);
  localparam mode_t MODE_RST = '1;

  mode_t            mode_r;
  logic             pin_edge;
  logic             src_tick;
  logic             pre_inc;
  logic             pre_clr;
  logic             pre_carry;
  logic [EXP_W-1:0] exp_sel;
  logic             cnt_step;
  logic             wd_step;
  logic             wd_clear;
  logic             wdt_expire;
  logic [WDT_W-1:0] wd_cnt;
  logic             sleep_r;
  logic             to_r, pd_r;
  logic [CNT_W-1:0] cnt_r;
  logic             wrap_r, wrst_r;

  tw_pin_edge u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .fall_sel(mode_r.fall_edge), .edge_pulse(pin_edge)
  );

  assign src_tick = mode_r.src_pin ? pin_edge : (cyc_tick & ~sleep_r);
  assign pre_inc  = mode_r.pre_wd ? wdt_tick : src_tick;
  assign exp_sel  = div_exp(mode_r.ps, mode_r.pre_wd);
  assign wd_clear = clrwdt | sleep_cmd | mclr_req;
  assign pre_clr  = mclr_req | wdt_expire | mode_we |
                    (mode_r.pre_wd ? (clrwdt | sleep_cmd) : cnt_we);

  tw_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clr(pre_clr), .inc(pre_inc),
    .exp_sel(exp_sel), .carry(pre_carry)
  );

  assign cnt_step = mode_r.pre_wd ? src_tick : pre_carry;
  assign wd_step  = mode_r.pre_wd ? pre_carry : wdt_tick;

  tw_wdog #(.LIMIT(WDT_LIMIT), .W(WDT_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .en(wdt_en), .clr(wd_clear),
    .step(wd_step), .expire(wdt_expire), .cnt_q(wd_cnt)
  );

  // Counter with load priority and wrap pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r  <= '0;
      wrap_r <= 1'b0;
    end else begin
      wrap_r <= cnt_step && !cnt_we && (cnt_r == '1);
      if (cnt_we)        cnt_r <= cnt_wdata;
      else if (cnt_step) cnt_r <= cnt_r + CNT_W'(1);
    end
  end

  // Mode register: any reset source forces all ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       mode_r <= MODE_RST;
    else if (mclr_req || wdt_expire)  mode_r <= MODE_RST;
    else if (mode_we)                 mode_r <= mode_t'(mode_wdata);
  end

  // Sleep state and status flags.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_r <= 1'b0;
      to_r    <= 1'b1;
      pd_r    <= 1'b1;
      wrst_r  <= 1'b0;
    end else begin
      wrst_r <= wdt_expire;
      if (mclr_req) begin
        if (sleep_r) begin
          to_r <= 1'b1;
          pd_r <= 1'b0;
        end
        sleep_r <= 1'b0;
      end else if (wdt_expire) begin
        to_r    <= 1'b0;
        pd_r    <= ~sleep_r;
        sleep_r <= 1'b0;
      end else if (clrwdt || sleep_cmd) begin
        to_r <= 1'b1;
        pd_r <= 1'b1;
        if (sleep_cmd) sleep_r <= 1'b1;
      end
    end
  end

  assign mode_q   = mode_r;
  assign count_q  = cnt_r;
  assign cnt_wrap = wrap_r;
  assign wdt_rst  = wrst_r;
  assign asleep   = sleep_r;
  assign flag_to  = to_r;
  assign flag_pd  = pd_r;
endmodule

// File: rtl/tw_chk.sv
module tw_chk #(
  parameter int CNT_W  = 8,
  parameter int LIMIT  = 20000,
  parameter int WDW    = $clog2(LIMIT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [5:0]       mode_q,
  input logic [CNT_W-1:0] count_q,
  input logic             cnt_wrap,
  input logic             wdt_rst,
  input logic             asleep,
  input logic             flag_to,
  input logic             flag_pd,
  input logic             clrwdt,
  input logic             mclr_req,
  input logic             cnt_we,
  input logic             wdt_expire,
  input logic [WDW-1:0]   wd_cnt
);
  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap |-> (count_q == '0));

  assert_expire_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_expire |=> (mode_q == 6'h3F && wdt_rst && !asleep));

  assert_wd_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_cnt < WDW'(LIMIT));

  assert_clear_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clrwdt && !mclr_req) |=> (flag_to && flag_pd));

  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !mode_q[5] && !cnt_we) |=> (count_q == $past(count_q)));

  assert_expire_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_expire |=> (!flag_to && (flag_pd == !$past(asleep))));

  assert_mclr_sleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr_req && asleep) |=> (flag_to && !flag_pd && !asleep));

  assert_mclr_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_req |=> (mode_q == 6'h3F));
endmodule

bind tmr_wdog_unit tw_chk #(.CNT_W(CNT_W), .LIMIT(WDT_LIMIT), .WDW(WDT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .count_q(count_q),
  .cnt_wrap(cnt_wrap), .wdt_rst(wdt_rst), .asleep(asleep),
  .flag_to(flag_to), .flag_pd(flag_pd), .clrwdt(clrwdt),
  .mclr_req(mclr_req), .cnt_we(cnt_we), .wdt_expire(wdt_expire),
  .wd_cnt(wd_cnt)
);

// File: tb/sim_tmr_wdog_unit.sv
module sim_tmr_wdog_unit;
  localparam int LIM = 16;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       cyc_tick = 0, wdt_tick = 0, ext_pin = 0, wdt_en = 1;
  logic       mode_we = 0, cnt_we = 0, clrwdt = 0, sleep_cmd = 0, mclr_req = 0;
  logic [5:0] mode_wdata = '0;
  logic [7:0] cnt_wdata = '0;
  logic [5:0] mode_q;
  logic [7:0] count_q;
  logic       cnt_wrap, wdt_rst, asleep, flag_to, flag_pd;
  int checks = 0, fails = 0;
  bit done = 0;
  bit seen;

  always #5 clk = ~clk;

  tmr_wdog_unit #(.CNT_W(8), .WDT_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .wdt_tick(wdt_tick),
    .ext_pin(ext_pin), .wdt_en(wdt_en), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .clrwdt(clrwdt), .sleep_cmd(sleep_cmd),
    .mclr_req(mclr_req), .mode_q(mode_q), .count_q(count_q), .cnt_wrap(cnt_wrap),
    .wdt_rst(wdt_rst), .asleep(asleep), .flag_to(flag_to), .flag_pd(flag_pd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk) cyc_tick = 1;
      @(negedge clk) cyc_tick = 0;
    end
  endtask

  task automatic wtick(input int n);
    repeat (n) begin
      @(negedge clk) wdt_tick = 1;
      @(negedge clk) wdt_tick = 0;
      if (wdt_rst) seen = 1;
    end
  endtask

  task automatic wr_mode(input logic [5:0] v);
    @(negedge clk) begin mode_we = 1; mode_wdata = v; end
    @(negedge clk) mode_we = 0;
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk) begin cnt_we = 1; cnt_wdata = v; end
    @(negedge clk) cnt_we = 0;
  endtask

  task automatic do_clr();
    @(negedge clk) clrwdt = 1;
    @(negedge clk) clrwdt = 0;
  endtask

  task automatic do_sleep();
    @(negedge clk) sleep_cmd = 1;
    @(negedge clk) sleep_cmd = 0;
  endtask

  task automatic do_mclr();
    @(negedge clk) mclr_req = 1;
    @(negedge clk) mclr_req = 0;
  endtask

  task automatic pin_to(input logic v);
    @(negedge clk) ext_pin = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode_q, 6'h3F);
    chk("R1 count", count_q, 0);
    chk("R1 flags", {flag_to, flag_pd}, 2'b11);
    chk("R1 sleep/pulses", {asleep, cnt_wrap, wdt_rst}, 3'b000);
  endtask

  task automatic t_counter_prescaled();
    wr_mode(6'h00);
    chk("R2 mode readback", mode_q, 6'h00);
    load(8'h00);
    cyc(10);
    chk("R3 ps0 div2", count_q, 8'd5);
    wr_mode(6'h07);
    load(8'h00);
    cyc(255);
    chk("R3 ps7 before 256", count_q, 8'd0);
    cyc(1);
    chk("R3 ps7 at 256", count_q, 8'd1);
    cyc(200);
    wr_mode(6'h07);
    cyc(255);
    chk("R2 mode write clears prescaler", count_q, 8'd1);
    cyc(1);
    chk("R2 count after clear", count_q, 8'd2);
  endtask

  task automatic t_counter_direct();
    wr_mode(6'h08);
    load(8'h10);
    cyc(7);
    chk("R4 direct step", count_q, 8'h17);
  endtask

  task automatic t_pin();
    wr_mode(6'h28);
    load(8'h00);
    pin_to(1); pin_to(0); pin_to(1);
    chk("R5 rising edges", count_q, 8'd2);
    cyc(4);
    chk("R5 cycle tick ignored", count_q, 8'd2);
    wr_mode(6'h38);
    load(8'h00);
    pin_to(0);
    chk("R5 falling counted", count_q, 8'd1);
    pin_to(1);
    chk("R5 rising ignored", count_q, 8'd1);
    pin_to(0);
    chk("R5 second fall", count_q, 8'd2);
  endtask

  task automatic t_wrap();
    wr_mode(6'h08);
    load(8'hFE);
    cyc(1);
    chk("R6 pre-wrap", {cnt_wrap, count_q}, {1'b0, 8'hFF});
    @(negedge clk) cyc_tick = 1;
    @(negedge clk) cyc_tick = 0;
    chk("R6 wrap pulse", {cnt_wrap, count_q}, {1'b1, 8'h00});
    @(negedge clk);
    chk("R6 wrap one cycle", cnt_wrap, 0);
    @(negedge clk) begin cnt_we = 1; cnt_wdata = 8'h40; cyc_tick = 1; end
    @(negedge clk) begin cnt_we = 0; cyc_tick = 0; end
    chk("R6 load wins", count_q, 8'h40);
  endtask

  task automatic t_wd_direct();
    wr_mode(6'h00);
    do_clr();
    seen = 0;
    wtick(LIM - 1);
    chk("R7 no early reset", seen, 0);
    wtick(1);
    chk("R7 reset pulse", seen, 1);
    chk("R7 mode forced", mode_q, 6'h3F);
    chk("R10 flags awake", {flag_to, flag_pd}, 2'b01);
    @(negedge clk);
    chk("R7 pulse one cycle", wdt_rst, 0);
  endtask

  task automatic t_wd_clear();
    wr_mode(6'h00);
    do_clr();
    chk("R8 flags set", {flag_to, flag_pd}, 2'b11);
    seen = 0;
    wtick(10);
    do_clr();
    wtick(LIM - 1);
    chk("R8 count restarted", seen, 0);
    wtick(1);
    chk("R8 expiry after restart", seen, 1);
    wr_mode(6'h0A);
    do_clr();
    seen = 0;
    wtick(2);
    do_clr();
    wtick(4 * LIM - 1);
    chk("R8/R4 prescaler cleared, div4", seen, 0);
    wtick(1);
    chk("R4 watchdog div4 expiry", seen, 1);
  endtask

  task automatic t_sleep();
    wr_mode(6'h00);
    load(8'h00);
    do_sleep();
    chk("R9 asleep", asleep, 1);
    chk("R9 flags", {flag_to, flag_pd}, 2'b11);
    cyc(6);
    chk("R9 count held", count_q, 8'd0);
    seen = 0;
    wtick(LIM);
    chk("R10 sleep expiry", seen, 1);
    chk("R10 flags asleep", {flag_to, flag_pd, asleep}, 3'b000);
  endtask

  task automatic t_mclr();
    wr_mode(6'h15);
    load(8'h5A);
    do_mclr();
    chk("R11 mode", mode_q, 6'h3F);
    chk("R11 flags kept", {flag_to, flag_pd}, 2'b00);
    chk("R11 count kept", count_q, 8'h5A);
    do_sleep();
    do_mclr();
    chk("R11 sleep flags", {flag_to, flag_pd, asleep}, 3'b100);
    wr_mode(6'h00);
    do_clr();
    seen = 0;
    wtick(10);
    do_mclr();
    wr_mode(6'h00);
    wtick(LIM - 1);
    chk("R11 watchdog restarted", seen, 0);
    wtick(1);
    chk("R11 expiry after restart", seen, 1);
  endtask

  task automatic t_wd_off();
    @(negedge clk) wdt_en = 0;
    wr_mode(6'h00);
    seen = 0;
    wtick(3 * LIM);
    chk("R7 disabled", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_counter_prescaled();
    t_counter_direct();
    t_pin();
    t_wrap();
    t_wd_direct();
    t_wd_clear();
    t_sleep();
    t_mclr();
    t_wd_off();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule